// File: doc/BRIEF.md
# Strobed Input Port Handshake Controller

This block is an 8-bit parallel input port. A peripheral presents a byte on the port data pins and pulses STROBE. The port responds by pulling READY low when the pulse begins. When the pulse ends, it captures the byte into a buffer register and raises a pending interrupt towards the CPU. The CPU fetches the byte with a bus read addressed to the port. The TPB timing pulse of that read sequences the handshake. Its rising edge withdraws the interrupt. Its falling edge raises READY again, which tells the peripheral that the next byte may be sent.

The peripheral side behaves as a one-deep valid/ready stream. STROBE acts as the valid signal and READY as the ready signal. A peripheral is expected to start a strobe only while READY is high. Back-pressure is the time READY stays low, from the start of a strobe until the CPU completes a read of the port. If a strobe arrives while READY is low, the port still accepts it: the new byte overwrites the buffer, and READY stays low until a read finishes.

After an active-low clear, READY is low and no interrupt is pending. One dummy read of the port is therefore needed to raise READY the first time. STROBE, TPB and the port data pass through matched synchronisers, so every pin-to-output effect takes three clock edges. The chip select, address and read-strobe inputs must be held stable for the whole TPB pulse.

Top module: `strobe_in_port`

## Requirements
- R1: While `clear_n` is low, `ready_o` is 0 and `int_n_o` is 1. After a clear, a selected read returns 8'h00 on `rdata_o`.
- R2: The rising edge of `strobe_i` drives `ready_o` low, at the third clock edge after the pin changes.
- R3: The falling edge of `strobe_i` stores the `pdata_i` value present at that edge into the buffer and makes the interrupt pending. With `int_en_i` = 1, a pending interrupt drives `int_n_o` to 0.
- R4: The rising edge of `tpb_i` during a selected read clears the pending interrupt, so `int_n_o` returns to 1.
- R5: The falling edge of `tpb_i` sets `ready_o` high, provided the read was selected when that TPB pulse rose.
- R6: A dummy read after a clear raises `ready_o` and leaves `int_n_o` at 1.
- R7: A read is selected only when `cs_i` = 1, `rd_i` = 1 and `ra_i` = 2'b01. A TPB pulse during any other read changes neither `ready_o` nor `int_n_o`.
- R8: `rdata_o` carries the buffer contents during a selected read and is 8'h00 at every other time.
- R9: With `int_en_i` = 0, `int_n_o` stays 1 but the interrupt remains pending. Setting `int_en_i` to 1 later drives `int_n_o` low.
- R10: If a STROBE falling edge and a selected TPB rising edge are detected in the same cycle, the interrupt stays pending.
- R11: If a STROBE rising edge and a TPB falling edge are detected in the same cycle, `ready_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear_n | input | 1 | Active-low asynchronous clear |
| pdata_i | input | 8 | Peripheral data byte |
| strobe_i | input | 1 | Peripheral strobe, active high (stream valid) |
| ready_o | output | 1 | Port can accept a byte (stream ready) |
| cs_i | input | 1 | Chip select |
| ra_i | input | 2 | Register address; the port answers to 2'b01 |
| rd_i | input | 1 | CPU read strobe |
| tpb_i | input | 1 | CPU timing pulse that sequences the handshake |
| rdata_o | output | 8 | Read data; buffer on a selected read, otherwise zero |
| int_en_i | input | 1 | Interrupt output enable |
| int_n_o | output | 1 | Active-low interrupt request, open-drain style |

## Verification
Two pairs of events can land on the same clock edge. In the first pair, the peripheral ends a strobe while the CPU read's TPB rises, so the interrupt is set and cleared together. In the second pair, a new strobe begins while TPB falls, so READY is lowered and raised together. The bench provokes each pair by changing both raw pins at the same falling clock edge. The two synchronisers have equal depth, so the detected edges coincide exactly. The bench then judges the outcome at the ports: `int_n_o` must still be low after the first pair, and `ready_o` must still be low after the second.

// File: rtl/sip_pkg.sv
package sip_pkg;

  // Single-cycle edge events produced by a synchroniser
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

  localparam int unsigned SIP_DATA_W      = 8;
  localparam int unsigned SIP_ADDR_W      = 2;
  localparam int unsigned SIP_SYNC_STAGES = 2;

endpackage

// File: rtl/sip_edge_sync.sv
module sip_edge_sync
  import sip_pkg::*;
#(
  parameter int unsigned STAGES = SIP_SYNC_STAGES
) (
  input  logic      clk,
  input  logic      clear_n,
  input  logic      async_i,
  output edge_evt_t evt_o,
  output logic      level_o
);

  // shreg[STAGES-1] is the synchronised level, shreg[STAGES] its previous value
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      shreg <= '0;
    end else begin
      shreg <= {shreg[STAGES-1:0], async_i};
    end
  end

  assign level_o    = shreg[STAGES-1];
  assign evt_o.rise = shreg[STAGES-1] & ~shreg[STAGES];
  assign evt_o.fall = ~shreg[STAGES-1] & shreg[STAGES];

endmodule

// File: rtl/sip_data_pipe.sv
module sip_data_pipe #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);

  // Delays the data by the same number of stages as the strobe synchroniser
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge clear_n) begin
          if (!clear_n) stage_q[gi] <= '0;
          else          stage_q[gi] <= data_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge clear_n) begin
          if (!clear_n) stage_q[gi] <= '0;
          else          stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign data_o = stage_q[STAGES-1];

endmodule

// File: rtl/sip_buffer.sv
module sip_buffer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             read_sel_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] buf_q;

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      buf_q <= '0;
    end else if (load_i) begin
      buf_q <= data_i;
    end
  end

  // Bus is driven with the buffer only during a decoded read
  assign rdata_o = read_sel_i ? buf_q : '0;

endmodule

// File: rtl/sip_handshake.sv
module sip_handshake
  import sip_pkg::*;
(
  input  logic      clk,
  input  logic      clear_n,
  input  edge_evt_t stb_evt_i,
  input  edge_evt_t tpb_evt_i,
  input  logic      read_sel_i,
  output logic      ready_o,
  output logic      pending_o
);

  logic ready_q;
  logic pending_q;
  logic armed_q;

  // A read is armed when TPB rises while the port is decoded
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      armed_q <= 1'b0;
    end else if (tpb_evt_i.rise) begin
      armed_q <= read_sel_i;
    end else if (tpb_evt_i.fall) begin
      armed_q <= 1'b0;
    end
  end

  // Strobe leading edge wins over a read completion in the same cycle
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      ready_q <= 1'b0;
    end else if (stb_evt_i.rise) begin
      ready_q <= 1'b0;
    end else if (tpb_evt_i.fall && armed_q) begin
      ready_q <= 1'b1;
    end
  end

  // New data wins over an acknowledge in the same cycle
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      pending_q <= 1'b0;
    end else if (stb_evt_i.fall) begin
      pending_q <= 1'b1;
    end else if (tpb_evt_i.rise && read_sel_i) begin
      pending_q <= 1'b0;
    end
  end

  assign ready_o   = ready_q;
  assign pending_o = pending_q;

endmodule

// File: rtl/strobe_in_port.sv
module strobe_in_port
  import sip_pkg::*;
#(
  parameter int unsigned DATA_W      = SIP_DATA_W,
  parameter int unsigned ADDR_W      = SIP_ADDR_W,
  parameter int unsigned SYNC_STAGES = SIP_SYNC_STAGES,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 2'b01
) (
  input  logic              clk,
  input  logic              clear_n,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic              strobe_i,
  output logic              ready_o,
  input  logic              cs_i,
  input  logic [ADDR_W-1:0] ra_i,
  input  logic              rd_i,
  input  logic              tpb_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              int_en_i,
  output logic              int_n_o
);

  edge_evt_t         stb_evt;
  edge_evt_t         tpb_evt;
  logic              stb_level;
  logic              tpb_level;
  logic [DATA_W-1:0] pdata_sync;
  logic              read_sel;
  logic              int_pending;

  assign read_sel = cs_i & rd_i & (ra_i == PORT_ADDR);

  sip_edge_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
    .clk     (clk),
    .clear_n (clear_n),
    .async_i (strobe_i),
    .evt_o   (stb_evt),
    .level_o (stb_level)
  );

  sip_edge_sync #(.STAGES(SYNC_STAGES)) u_tpb_sync (
    .clk     (clk),
    .clear_n (clear_n),
    .async_i (tpb_i),
    .evt_o   (tpb_evt),
    .level_o (tpb_level)
  );

  sip_data_pipe #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_data_pipe (
    .clk     (clk),
    .clear_n (clear_n),
    .data_i  (pdata_i),
    .data_o  (pdata_sync)
  );

  sip_buffer #(.WIDTH(DATA_W)) u_buffer (
    .clk        (clk),
    .clear_n    (clear_n),
    .load_i     (stb_evt.fall),
    .data_i     (pdata_sync),
    .read_sel_i (read_sel),
    .rdata_o    (rdata_o)
  );

  sip_handshake u_handshake (
    .clk        (clk),
    .clear_n    (clear_n),
    .stb_evt_i  (stb_evt),
    .tpb_evt_i  (tpb_evt),
    .read_sel_i (read_sel),
    .ready_o    (ready_o),
    .pending_o  (int_pending)
  );

  // Open-drain style: pulled low only for an enabled pending request
  assign int_n_o = ~(int_pending & int_en_i);

endmodule

// File: rtl/strobe_in_port_checker.sv
module strobe_in_port_checker
  import sip_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 2'b01
) (
  input logic              clk,
  input logic              clear_n,
  input logic              cs_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] ra_i,
  input logic              int_en_i,
  input logic              ready_o,
  input logic              int_n_o,
  input logic [DATA_W-1:0] rdata_o,
  input edge_evt_t         stb_evt,
  input edge_evt_t         tpb_evt,
  input logic              int_pending
);

  assert_clear_idle_R1: assert property (@(posedge clk)
    !clear_n |-> (!ready_o && int_n_o));

  assert_strobe_drops_ready_R2: assert property (@(posedge clk) disable iff (!clear_n)
    stb_evt.rise |=> !ready_o);

  assert_strobe_end_pends_R3: assert property (@(posedge clk) disable iff (!clear_n)
    stb_evt.fall |=> int_pending);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!clear_n)
    (tpb_evt.rise && cs_i && rd_i && (ra_i == PORT_ADDR) && !stb_evt.fall) |=> !int_pending);

  assert_ready_from_tpb_R5: assert property (@(posedge clk) disable iff (!clear_n)
    $rose(ready_o) |-> $past(tpb_evt.fall));

  assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (!clear_n)
    (rdata_o != '0) |-> (cs_i && rd_i && (ra_i == PORT_ADDR)));

  assert_int_gated_R9: assert property (@(posedge clk) disable iff (!clear_n)
    !int_en_i |-> int_n_o);

endmodule

bind strobe_in_port strobe_in_port_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)
) chk_i (
  .clk         (clk),
  .clear_n     (clear_n),
  .cs_i        (cs_i),
  .rd_i        (rd_i),
  .ra_i        (ra_i),
  .int_en_i    (int_en_i),
  .ready_o     (ready_o),
  .int_n_o     (int_n_o),
  .rdata_o     (rdata_o),
  .stb_evt     (stb_evt),
  .tpb_evt     (tpb_evt),
  .int_pending (int_pending)
);

// File: tb/strobe_in_port_tb_top.sv
module strobe_in_port_tb_top;

  logic       clk = 1'b0;
  logic       clear_n;
  logic [7:0] pdata_i;
  logic       strobe_i;
  logic       ready_o;
  logic       cs_i;
  logic [1:0] ra_i;
  logic       rd_i;
  logic       tpb_i;
  logic [7:0] rdata_o;
  logic       int_en_i;
  logic       int_n_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  strobe_in_port dut_i (
    .clk(clk), .clear_n(clear_n), .pdata_i(pdata_i), .strobe_i(strobe_i),
    .ready_o(ready_o), .cs_i(cs_i), .ra_i(ra_i), .rd_i(rd_i), .tpb_i(tpb_i),
    .rdata_o(rdata_o), .int_en_i(int_en_i), .int_n_o(int_n_o)
  );

  // op: 0 strobe byte, 1 selected read, 2 read with cs low, 3 read at wrong address
  // fields: [27:24] op, [23:16] data, [15:12] ready after, [11:8] int_n after,
  //         [7:0] rdata seen during the op
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    28'h1_00_1_1_00,  // R6 dummy read after clear
    28'h0_A5_0_0_00,  // R3 byte arrives
    28'h2_00_0_0_00,  // R7 cs low
    28'h3_00_0_0_00,  // R7 wrong address
    28'h1_00_1_1_A5,  // R4 R5 R8 read it
    28'h0_3C_0_0_00,  // R3
    28'h0_C3_0_0_00,  // R3 overwrite while not ready
    28'h1_00_1_1_C3,  // R8 latest byte
    28'h0_5A_0_0_00,  // R2 R3
    28'h1_00_1_1_5A,  // R4 R5
    28'h1_00_1_1_5A   // R5 read with nothing pending
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_byte(input logic [7:0] d);
    pdata_i = d;
    strobe_i = 1'b1;
    wait_n(4);
    strobe_i = 1'b0;
    wait_n(4);
  endtask

  task automatic bus_read(input logic cs, input logic [1:0] ra, output logic [7:0] seen);
    cs_i = cs; ra_i = ra; rd_i = 1'b1;
    wait_n(2);
    seen = rdata_o;
    tpb_i = 1'b1;
    wait_n(4);
    tpb_i = 1'b0;
    wait_n(4);
    cs_i = 1'b0; rd_i = 1'b0; ra_i = 2'b00;
    wait_n(2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] seen;
    clear_n = 1'b0; pdata_i = '0; strobe_i = 0; cs_i = 0; ra_i = '0;
    rd_i = 0; tpb_i = 0; int_en_i = 1'b1;
    wait_n(3);
    check("R1 ready in clear", {7'd0, ready_o}, 8'h00);
    check("R1 int_n in clear", {7'd0, int_n_o}, 8'h01);
    clear_n = 1'b1;
    wait_n(2);
    cs_i = 1; rd_i = 1; ra_i = 2'b01;
    wait_n(1);
    check("R1 buffer after clear", rdata_o, 8'h00);
    cs_i = 0; rd_i = 0; ra_i = 2'b00;
    check("R8 bus idle", rdata_o, 8'h00);
    wait_n(2);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      op = VEC[i][27:24];
      seen = 8'h00;
      case (op)
        4'd0: strobe_byte(VEC[i][23:16]);
        4'd1: bus_read(1'b1, 2'b01, seen);
        4'd2: bus_read(1'b0, 2'b01, seen);
        default: bus_read(1'b1, 2'b10, seen);
      endcase
      check($sformatf("R3/R5/R7 vector %0d ready", i), {7'd0, ready_o}, {4'd0, VEC[i][15:12]});
      check($sformatf("R3/R4/R7 vector %0d int_n", i), {7'd0, int_n_o}, {4'd0, VEC[i][11:8]});
      check($sformatf("R8 vector %0d rdata", i), seen, VEC[i][7:0]);
    end

    // R2: ready drops mid-strobe (ready is 1 here)
    pdata_i = 8'h81; strobe_i = 1'b1;
    wait_n(4);
    check("R2 ready low during strobe", {7'd0, ready_o}, 8'h00);
    check("R3 int not pending before strobe end", {7'd0, int_n_o}, 8'h01);
    strobe_i = 1'b0;
    wait_n(4);
    bus_read(1'b1, 2'b01, seen);
    check("R8 byte 81", seen, 8'h81);

    // R9: interrupt gating
    int_en_i = 1'b0;
    strobe_byte(8'h42);
    check("R9 int_n held high", {7'd0, int_n_o}, 8'h01);
    int_en_i = 1'b1;
    wait_n(1);
    check("R9 pending shows when enabled", {7'd0, int_n_o}, 8'h00);
    bus_read(1'b1, 2'b01, seen);
    check("R4 ack after R9", {7'd0, int_n_o}, 8'h01);

    // R10: strobe end and selected TPB rise on the same edge
    cs_i = 1; rd_i = 1; ra_i = 2'b01;
    pdata_i = 8'h77; strobe_i = 1'b1;
    wait_n(4);
    strobe_i = 1'b0; tpb_i = 1'b1;
    wait_n(4);
    tpb_i = 1'b0;
    wait_n(4);
    check("R10 int stays pending", {7'd0, int_n_o}, 8'h00);
    check("R5 ready after coincident read", {7'd0, ready_o}, 8'h01);
    check("R10 buffer holds new byte", rdata_o, 8'h77);
    wait_n(1);

    // R11: strobe start and TPB fall on the same edge
    tpb_i = 1'b1;
    wait_n(4);
    check("R4 ack on tpb rise", {7'd0, int_n_o}, 8'h01);
    pdata_i = 8'h99; tpb_i = 1'b0; strobe_i = 1'b1;
    wait_n(4);
    check("R11 ready stays low", {7'd0, ready_o}, 8'h00);
    strobe_i = 1'b0;
    wait_n(4);
    check("R3 int after R11 strobe", {7'd0, int_n_o}, 8'h00);
    check("R3 byte 99", rdata_o, 8'h99);
    cs_i = 0; rd_i = 0; ra_i = 2'b00;
    wait_n(2);

    // R1: clear in mid-operation, then R6 dummy read again
    clear_n = 1'b0;
    wait_n(1);
    check("R1 int released by clear", {7'd0, int_n_o}, 8'h01);
    check("R1 ready low by clear", {7'd0, ready_o}, 8'h00);
    clear_n = 1'b1;
    wait_n(2);
    bus_read(1'b1, 2'b01, seen);
    check("R1 buffer cleared", seen, 8'h00);
    check("R6 ready after dummy read", {7'd0, ready_o}, 8'h01);
    check("R6 int untouched", {7'd0, int_n_o}, 8'h01);

    finish_run();
  end

endmodule